// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer. Each channel works in one of three ways. When it is off, it does nothing. In capture mode it stores the running counter when a chosen event occurs. In compare mode it watches the counter and reacts when the counter reaches a programmed value. A full timer peripheral places three copies of this channel beside a shared counter and precounter. Each copy receives the same counter words and its own configuration inputs.

In capture mode the channel takes one of twelve event lines and applies an edge filter to it. When a qualifying event occurs, the channel latches the counter into its value register. In compare mode the channel checks its value register against one of two words. The first is the full counter. The second is a combined word, made from the low 17 counter bits placed above the 15 precounter bits. A mask count can remove any number of the most significant bits from the comparison. A match fires only on the cycle in which equality first appears.

Every capture or match raises a one-cycle event flag. It also applies the selected action to the channel output: a single-cycle pulse, a toggle, a clear or a set.

Top module: `timer_cc_channel`

## Requirements
- R1: After reset `val_o`, `out_o` and `evt_o` are all 0.
- R2: `cfg_mode` encodes 0 = off, 1 = capture, 2 = compare, and 3 = reserved, which behaves as off. While the channel is off or reserved, no event occurs and `out_o` is driven to 0 on the next edge.
- R3: In compare mode, `cfg_base` = 0 compares `val_o` with `cnt_i`. `cfg_base` = 1 compares `val_o` with `{cnt_i[16:0], precnt_i[14:0]}`.
- R4: `cfg_mask` = m removes the m most significant bits of the 32-bit word from the comparison. With m = 31, only bit 0 is compared.
- R5: A match fires only on a cycle where the masked words are equal and were not equal, in compare mode, on the previous cycle. A counter that holds at the matching value does not fire again. Entering compare mode while the words are already equal counts as a new match.
- R6: `evt_o` is high for exactly the one cycle after the clock edge at which a capture or match condition was sampled.
- R7: `cfg_action` sets the output action on each capture or match: 0 = pulse (high for exactly one cycle, low otherwise), 1 = toggle, 2 = clear, 3 = set.
- R8: `cfg_src` values 0 to 11 select event line `evt_in[cfg_src]`; values 12 to 15 select no line. Lines that are not selected have no effect.
- R9: `cfg_edge` encodes 0 = rising, 1 = falling, 2 = both edges, 3 = level. In level mode, every cycle in which the selected line is high counts as an event.
- R10: A capture loads `cnt_i`, as sampled at that edge, into `val_o` on the same edge that raises `evt_o`.
- R11: When `val_wr` is high, `val_wdata` is loaded into `val_o`. A capture in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Channel mode |
| cfg_action | input | 2 | Output action on capture or match |
| cfg_edge | input | 2 | Capture edge filter |
| cfg_src | input | 4 | Capture event line select |
| cfg_base | input | 1 | Compare word select |
| cfg_mask | input | 5 | Number of MSBs excluded from compare |
| cnt_i | input | 32 | Main counter |
| precnt_i | input | 15 | Precounter |
| evt_in | input | 12 | Event lines |
| val_wr | input | 1 | Value register write strobe |
| val_wdata | input | 32 | Value register write data |
| val_o | output | 32 | Channel value register |
| evt_o | output | 1 | One-cycle event flag |
| out_o | output | 1 | Channel output |

## Verification
The assertions assume the following about the inputs:
- Configuration inputs change only on clock edges.
- The reset is held long enough for the event-line history to be cleared.
- The no-retrigger property assumes that the compared word, the value and the mask are held steady for a cycle after a match.

The stimulus drives every input on the falling clock edge. It changes the mode or the compare word between table rows by passing through the off mode, so that each row starts with no stale match history.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_COMPARE = 2'd2,
        CH_RSVD    = 2'd3
    } ch_mode_e;

    typedef enum logic [1:0] {
        ACT_PULSE  = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } out_act_e;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_LEVEL = 2'd3
    } edge_sel_e;

endpackage

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel
    import tcc_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [SRC_W-1:0]   src_i,
    input  edge_sel_e          edge_i,
    output logic               trig_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     sel;
    logic     src_bad;

    assign src_bad = (int'(src_i) >= NUM_SRC);

    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(src_i) == i) sel = evt_i[i];
        end
        st_d.prev = sel;
        unique case (edge_i)
            EDG_RISE: trig_o = sel & ~st_q.prev;
            EDG_FALL: trig_o = ~sel & st_q.prev;
            EDG_BOTH: trig_o = sel ^ st_q.prev;
            default:  trig_o = sel;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    bad_src_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_bad |=> (!src_bad || !trig_o));

endmodule

// File: rtl/tcc_cmp.sv
module tcc_cmp
    import tcc_pkg::*;
#(
    parameter int VAL_W  = 32,
    parameter int PRE_W  = 15,
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              base_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [VAL_W-1:0]  val_i,
    output logic              hit_o
);

    localparam int HI_W = VAL_W - PRE_W;

    typedef struct packed {
        logic eq_prev;
    } cmp_st_t;

    cmp_st_t          st_d, st_q;
    logic [VAL_W-1:0] comb_word;
    logic [VAL_W-1:0] word;
    logic [VAL_W-1:0] keep;
    logic             eq;

    if (HI_W > 0) begin : g_joined
        assign comb_word = {cnt_i[HI_W-1:0], pre_i};
    end else begin : g_pre_only
        assign comb_word = pre_i[VAL_W-1:0];
    end

    always_comb begin
        word         = base_i ? comb_word : cnt_i;
        keep         = {VAL_W{1'b1}} >> mask_i;
        eq           = (((word ^ val_i) & keep) == '0);
        st_d.eq_prev = en_i & eq;
        hit_o        = en_i & eq & ~st_q.eq_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!hit_o || !$stable(word) || !$stable(val_i)
                   || !$stable(keep) || !$stable(en_i)));

endmodule

// File: rtl/tcc_out_act.sv
module tcc_out_act
    import tcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     hit_i,
    input  out_act_e act_i,
    output logic     out_o
);

    typedef struct packed {
        logic out;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.out = 1'b0;
        end else begin
            unique case (act_i)
                ACT_PULSE:  st_d.out = hit_i;
                ACT_TOGGLE: st_d.out = st_q.out ^ hit_i;
                ACT_CLEAR:  st_d.out = hit_i ? 1'b0 : st_q.out;
                default:    st_d.out = hit_i ? 1'b1 : st_q.out;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R7
    pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hit_i && act_i == ACT_PULSE) |=> out_o);

    // R7
    pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && act_i == ACT_PULSE) |=> !out_o);

endmodule

// File: rtl/timer_cc_channel.sv
module timer_cc_channel
    import tcc_pkg::*;
#(
    parameter int  VAL_W   = 32,
    parameter int  PRE_W   = 15,
    parameter int  NUM_SRC = 12,
    parameter int  MASK_W  = 5,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_action,
    input  logic [1:0]         cfg_edge,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic               cfg_base,
    input  logic [MASK_W-1:0]  cfg_mask,
    input  logic [VAL_W-1:0]   cnt_i,
    input  logic [PRE_W-1:0]   precnt_i,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               val_wr,
    input  logic [VAL_W-1:0]   val_wdata,
    output logic [VAL_W-1:0]   val_o,
    output logic               evt_o,
    output logic               out_o
);

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic             evt;
    } chan_st_t;

    chan_st_t  st_d, st_q;
    ch_mode_e  mode;
    out_act_e  act;
    edge_sel_e edg;
    logic      trig;
    logic      cap_hit;
    logic      cmp_en;
    logic      cmp_hit;
    logic      hit;
    logic      idle;

    assign mode = ch_mode_e'(cfg_mode);
    assign act  = out_act_e'(cfg_action);
    assign edg  = edge_sel_e'(cfg_edge);

    tcc_edge_sel #(
        .NUM_SRC (NUM_SRC)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_in),
        .src_i  (cfg_src),
        .edge_i (edg),
        .trig_o (trig)
    );

    tcc_cmp #(
        .VAL_W  (VAL_W),
        .PRE_W  (PRE_W),
        .MASK_W (MASK_W)
    ) cmp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cmp_en),
        .base_i (cfg_base),
        .mask_i (cfg_mask),
        .cnt_i  (cnt_i),
        .pre_i  (precnt_i),
        .val_i  (st_q.val),
        .hit_o  (cmp_hit)
    );

    tcc_out_act act_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (idle),
        .hit_i (hit),
        .act_i (act),
        .out_o (out_o)
    );

    always_comb begin
        cmp_en  = (mode == CH_COMPARE);
        cap_hit = (mode == CH_CAPTURE) & trig;
        idle    = (mode != CH_COMPARE) && (mode != CH_CAPTURE);
        hit     = cap_hit | cmp_hit;

        st_d     = st_q;
        st_d.evt = hit;
        if (cap_hit)     st_d.val = cnt_i;
        else if (val_wr) st_d.val = val_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;
    assign evt_o = st_q.evt;

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (!evt_o && !out_o));

    // R10
    capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_CAPTURE && trig) |=> (evt_o && val_o == $past(cnt_i)));

    // R6
    evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_hit && !cmp_hit) |=> !evt_o);

endmodule

// File: tb/timer_cc_channel_tb_top.sv
`timescale 1ns/1ps
module timer_cc_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode, cfg_action, cfg_edge;
    logic [3:0]  cfg_src;
    logic        cfg_base;
    logic [4:0]  cfg_mask;
    logic [31:0] cnt_i;
    logic [14:0] precnt_i;
    logic [11:0] evt_in;
    logic        val_wr;
    logic [31:0] val_wdata;
    logic [31:0] val_o;
    logic        evt_o, out_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    timer_cc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_action(cfg_action),
        .cfg_edge(cfg_edge), .cfg_src(cfg_src), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cnt_i(cnt_i), .precnt_i(precnt_i), .evt_in(evt_in),
        .val_wr(val_wr), .val_wdata(val_wdata), .val_o(val_o), .evt_o(evt_o),
        .out_o(out_o)
    );

    // base, mask, value, counter, precounter, expected match
    localparam logic [85:0] VECS [9] = '{
        {1'b0, 5'd0,  32'h12345678, 32'h12345678, 15'h0000, 1'b1},
        {1'b0, 5'd0,  32'h12345678, 32'h12345679, 15'h0000, 1'b0},
        {1'b0, 5'd8,  32'hAB000010, 32'h00000010, 15'h0000, 1'b1},
        {1'b0, 5'd7,  32'hAB000010, 32'h00000010, 15'h0000, 1'b0},
        {1'b1, 5'd0,  32'h91A29ABC, 32'hFFFF2345, 15'h1ABC, 1'b1},
        {1'b1, 5'd0,  32'h91A29ABC, 32'hFFFF2345, 15'h1ABD, 1'b0},
        {1'b0, 5'd0,  32'h91A29ABC, 32'hFFFF2345, 15'h1ABC, 1'b0},
        {1'b0, 5'd31, 32'h00000001, 32'hFFFFFFFF, 15'h0000, 1'b1},
        {1'b0, 5'd31, 32'h00000000, 32'h00000003, 15'h0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'd0; cfg_action = 2'd3; cfg_edge = 2'd0;
        cfg_src = 4'd0; cfg_base = 1'b0; cfg_mask = 5'd0; cnt_i = '0;
        precnt_i = '0; evt_in = '0; val_wr = 1'b0; val_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1
        chk("R1 val", val_o, 32'h0);
        chk("R1 evt", {31'b0, evt_o}, 32'h0);
        chk("R1 out", {31'b0, out_o}, 32'h0);

        // R3 R4 table walk with set action
        for (int i = 0; i < 9; i++) begin
            cfg_mode = 2'd0; val_wr = 1'b1; val_wdata = VECS[i][79:48];
            step();
            val_wr = 1'b0; cfg_mode = 2'd2; cfg_action = 2'd3;
            cfg_base = VECS[i][85]; cfg_mask = VECS[i][84:80];
            cnt_i = VECS[i][47:16]; precnt_i = VECS[i][15:1];
            step();
            chk($sformatf("R3/R4 row %0d evt", i), {31'b0, evt_o}, {31'b0, VECS[i][0]});
            chk($sformatf("R7 set row %0d out", i), {31'b0, out_o}, {31'b0, VECS[i][0]});
        end

        // R5 first-equal and R7 toggle
        cfg_mode = 2'd0; val_wr = 1'b1; val_wdata = 32'd100; cfg_base = 1'b0;
        cfg_mask = 5'd0; cnt_i = 32'd100; cfg_action = 2'd1;
        step();
        val_wr = 1'b0; cfg_mode = 2'd2;
        step();
        chk("R5 entry match evt", {31'b0, evt_o}, 32'h1);
        chk("R7 toggle up", {31'b0, out_o}, 32'h1);
        step();
        chk("R5 hold no retrigger", {31'b0, evt_o}, 32'h0);
        chk("R6 evt one cycle out held", {31'b0, out_o}, 32'h1);
        cnt_i = 32'd101; step();
        chk("R5 mismatch", {31'b0, evt_o}, 32'h0);
        cnt_i = 32'd100; step();
        chk("R5 rematch", {31'b0, evt_o}, 32'h1);
        chk("R7 toggle down", {31'b0, out_o}, 32'h0);

        // R7 set then clear
        cfg_action = 2'd3; cnt_i = 32'd101; step();
        cnt_i = 32'd100; step();
        chk("R7 set", {31'b0, out_o}, 32'h1);
        cfg_action = 2'd2; cnt_i = 32'd101; step();
        chk("R7 clear holds without hit", {31'b0, out_o}, 32'h1);
        cnt_i = 32'd100; step();
        chk("R7 clear", {31'b0, out_o}, 32'h0);

        // R7 pulse one cycle
        cfg_action = 2'd0; cnt_i = 32'd101; step();
        cnt_i = 32'd100; step();
        chk("R7 pulse high", {31'b0, out_o}, 32'h1);
        step();
        chk("R7 pulse low", {31'b0, out_o}, 32'h0);

        // R2 off and reserved
        cfg_action = 2'd3; cfg_mode = 2'd0; step();
        chk("R2 off evt", {31'b0, evt_o}, 32'h0);
        cfg_mode = 2'd3; step();
        chk("R2 reserved evt", {31'b0, evt_o}, 32'h0);
        chk("R2 reserved out", {31'b0, out_o}, 32'h0);

        // Capture on line 5
        cfg_mode = 2'd0; cfg_edge = 2'd0; cfg_src = 4'd5; evt_in = '0; step();
        cfg_mode = 2'd1; cnt_i = 32'h1111; step();
        chk("R9 no edge", {31'b0, evt_o}, 32'h0);
        evt_in[5] = 1'b1; cnt_i = 32'h2222; step();
        chk("R9 rising evt", {31'b0, evt_o}, 32'h1);
        chk("R10 rising val", val_o, 32'h2222);
        cnt_i = 32'h3333; step();
        chk("R9 high held", {31'b0, evt_o}, 32'h0);
        chk("R10 val kept", val_o, 32'h2222);
        cfg_edge = 2'd1; evt_in[5] = 1'b0; cnt_i = 32'h4444; step();
        chk("R9 falling", val_o, 32'h4444);
        cfg_edge = 2'd2; evt_in[5] = 1'b1; cnt_i = 32'h5555; step();
        chk("R9 both rise", val_o, 32'h5555);
        evt_in[5] = 1'b0; cnt_i = 32'h6666; step();
        chk("R9 both fall", val_o, 32'h6666);
        cfg_edge = 2'd3; evt_in[5] = 1'b1; cnt_i = 32'h7777; step();
        chk("R9 level 1", val_o, 32'h7777);
        cnt_i = 32'h7778; step();
        chk("R9 level 2 evt", {31'b0, evt_o}, 32'h1);
        chk("R9 level 2 val", val_o, 32'h7778);
        evt_in[5] = 1'b0; step();
        chk("R9 level low", {31'b0, evt_o}, 32'h0);

        // R8 unselected lines and invalid select
        cfg_edge = 2'd2; evt_in = 12'hFDF; cnt_i = 32'h8888; step();
        chk("R8 unselected evt", {31'b0, evt_o}, 32'h0);
        chk("R8 unselected val", val_o, 32'h7778);
        evt_in = '0; step();
        cfg_src = 4'd12; cfg_edge = 2'd3; evt_in = 12'hFFF; step();
        chk("R8 code 12 evt", {31'b0, evt_o}, 32'h0);
        chk("R8 code 12 val", val_o, 32'h7778);
        cfg_src = 4'd11; step();
        chk("R8 line 11", val_o, 32'h8888);

        // R11 write vs capture
        cnt_i = 32'h9999; val_wr = 1'b1; val_wdata = 32'hDEAD; step();
        chk("R11 capture wins", val_o, 32'h9999);
        evt_in = '0; val_wdata = 32'hBEEF; step();
        val_wr = 1'b0;
        chk("R11 write", val_o, 32'hBEEF);
        chk("R6 no evt on write", {31'b0, evt_o}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule